// File: doc/BRIEF.md
# Shared-Multiplier FIR Filter

This block is a finite impulse response filter that owns one signed multiplier and one accumulator and steps them across every tap in turn. Each accepted input sample is written into a circular history store. The filter then spends one clock cycle per tap multiplying a stored coefficient by the matching past sample and adding the product to a running sum. The block is meant for sample rates far below the clock rate, where one multiplier can cover all taps in time.

A small sequencer drives the coefficient index, the history read address and the clear of the running sum. On the first tap, the feedback path into the adder selects zero instead of the old sum, so each output starts from a clean total. Coefficients can be loaded through a write port, but only while the filter is idle. The finished sum is scaled by an arithmetic right shift and clamped to the output width.

Top module: `shared_mac_fir`

## Requirements
- R1: After reset, `busy`, `out_valid` and `out_data` are 0, and every coefficient and every stored sample is 0, so the first output after reset with no coefficient writes is 0.
- R2: A coefficient write (`coef_we` high while `busy` is low) stores `coef_data` as the coefficient of tap `coef_addr`. Tap 0 weights the newest sample and tap k weights the sample accepted k samples earlier.
- R3: A coefficient write while `busy` is high is ignored and does not alter any later output.
- R4: A sample is accepted only on a rising edge where `in_valid` is high and `busy` is low. `in_valid` while `busy` is high is ignored, and that sample never enters the history.
- R5: For accepted sample n, the full sum is S = Σ_{k=0}^{TAPS-1} c[k]·x[n−k], where samples before the first accepted one count as zero and the history wraps circularly over TAPS entries.
- R6: `busy` rises on the accepting edge and stays high for exactly TAPS+1 cycles. `out_valid` is a one-cycle pulse on the (TAPS+1)-th rising edge after the accepting edge, in the same cycle that `busy` returns low.
- R7: The running sum is cleared at the start of each output, so an output depends only on the current coefficients and the last TAPS samples, never on earlier sums.
- R8: `out_data` equals S arithmetically shifted right by SHIFT (rounding toward minus infinity), clamped to the signed OW-bit range [−2^(OW−1), 2^(OW−1)−1].
- R9: `out_data` holds its value from one `out_valid` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Offers `in_data` as a new sample |
| in_data | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | AW | Tap index for a coefficient write |
| coef_data | input | CW | Signed coefficient value |
| busy | output | 1 | High while an output is being computed |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OW | Scaled and clamped signed result |

## Verification
The sum is checked against a model under an impulse, a mixed-sign sequence that wraps the circular history, and a long run of zeros. The zero run shows that old samples age out and that the running sum does not leak from one output into the next. Saturating runs with all coefficients and samples at full positive or full negative scale check both clamp limits. A single-tap case with small negative and positive samples checks that the shift rounds toward minus infinity. Separate runs drive a coefficient write and a sample offer in the middle of a computation, so that an ignored write or sample shows up as a wrong later output.

// File: rtl/shared_mac_fir.sv
module shared_mac_fir #(
  parameter int TAPS  = 8,
  parameter int DW    = 18,
  parameter int CW    = 18,
  parameter int OW    = 18,
  parameter int SHIFT = CW - 1,
  localparam int AW   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 coef_we,
  input  logic        [AW-1:0] coef_addr,
  input  logic signed [CW-1:0] coef_data,
  output logic                 busy,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int PW   = DW + CW;
  localparam int ACCW = PW + AW;
  localparam logic [AW:0]   NTAP = TAPS[AW:0];
  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);
  localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

  logic signed [CW-1:0] coef [TAPS];
  logic signed [DW-1:0] hist [TAPS];
  logic [AW-1:0] wp, base, k;
  logic run, fin, clr;
  logic signed [ACCW-1:0] acc;

  assign busy = run | fin;
  wire accept = in_valid & ~busy;

  wire [AW:0]   diff = ({1'b0, base} >= {1'b0, k}) ? {1'b0, base} - {1'b0, k}
                                                   : {1'b0, base} + NTAP - {1'b0, k};
  wire [AW-1:0] rd   = diff[AW-1:0];
  wire [AW-1:0] wp_n = (wp == LAST) ? '0 : wp + 1'b1;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_x, acc_fb, sum;
  assign prod   = coef[k] * hist[rd];
  assign prod_x = ACCW'(prod);
  assign acc_fb = clr ? '0 : acc;
  assign sum    = acc_fb + prod_x;

  logic signed [ACCW-1:0] scaled;
  logic signed [OW-1:0]   clamp;
  wire [ACCW-OW:0] top = scaled[ACCW-1:OW-1];
  assign scaled = acc >>> SHIFT;
  always_comb begin
    if (!scaled[ACCW-1] && (|top))      clamp = MAXV;
    else if (scaled[ACCW-1] && !(&top)) clamp = MINV;
    else                                clamp = scaled[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) begin
        coef[i] <= '0;
        hist[i] <= '0;
      end
      wp <= '0; base <= '0; k <= '0;
      run <= 1'b0; fin <= 1'b0; clr <= 1'b0;
      acc <= '0; out_valid <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      if (coef_we && !busy && ({1'b0, coef_addr} < NTAP))
        coef[coef_addr] <= coef_data;
      if (accept) begin
        hist[wp] <= in_data;
        base <= wp;
        wp   <= wp_n;
        k    <= '0;
        run  <= 1'b1;
        clr  <= 1'b1;
      end
      if (run) begin
        acc <= sum;
        clr <= 1'b0;
        if (k == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          k <= k + 1'b1;
        end
      end
      if (fin) begin
        fin       <= 1'b0;
        out_valid <= 1'b1;
        out_data  <= clamp;
      end
    end
  end
endmodule

// File: rtl/shared_mac_fir_chk.sv
module shared_mac_fir_chk #(
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          busy,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_done_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind shared_mac_fir shared_mac_fir_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_shared_mac_fir.sv
module test_shared_mac_fir;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 8, DW = 18, CW = 18, OW = 18, SHIFT = 17, AW = 3;
  localparam longint OMAX = 131071, OMIN = -131072;

  logic clk = 0, rst_n = 0, in_valid = 0, coef_we = 0;
  logic signed [DW-1:0] in_data = '0;
  logic [AW-1:0] coef_addr = '0;
  logic signed [CW-1:0] coef_data = '0;
  logic busy, out_valid;
  logic signed [OW-1:0] out_data;

  shared_mac_fir #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .SHIFT(SHIFT)) i_shared_mac_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  longint cm [TAPS];
  longint hm [TAPS];
  int wpm = 0;

  localparam int NV = 14;
  localparam logic signed [17:0] STIM [NV] = '{
    18'sd1000, -18'sd2000, 18'sd131071, -18'sd131072, 18'sd77, -18'sd5,
    18'sd0, 18'sd0, 18'sd0, 18'sd0, 18'sd0, 18'sd0, 18'sd0, 18'sd0 };
  localparam string SREQ [NV] = '{
    "R5", "R5", "R5", "R5", "R5", "R5",
    "R7", "R7", "R7", "R7", "R7", "R7", "R7", "R7" };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint x);
    longint s, y;
    int base;
    hm[wpm] = x;
    base = wpm;
    wpm = (wpm + 1) % TAPS;
    s = 0;
    for (int j = 0; j < TAPS; j++) s += cm[j] * hm[(base - j + TAPS) % TAPS];
    y = s >>> SHIFT;
    if (y > OMAX) y = OMAX;
    if (y < OMIN) y = OMIN;
    return y;
  endfunction

  task automatic wcoef(input int a, input longint v);
    @(negedge clk);
    coef_we = 1; coef_addr = AW'(a); coef_data = CW'(v);
    @(negedge clk);
    coef_we = 0;
    cm[a] = v;
  endtask

  // mode 0: plain; 1: coefficient write mid-run; 2: sample offered mid-run
  task automatic run(input longint x, input int mode, input longint dval, input string req);
    longint exp;
    int cnt;
    @(negedge clk);
    in_valid = 1; in_data = DW'(x);
    @(negedge clk);
    in_valid = 0;
    exp = model(x);
    cnt = 1;
    while (!out_valid && cnt < 64) begin
      if (cnt == 3 && mode == 1) begin
        chk("R3 busy during write", busy, 1);
        coef_we = 1; coef_addr = 0; coef_data = CW'(dval);
      end else if (cnt == 3 && mode == 2) begin
        chk("R4 busy during offer", busy, 1);
        in_valid = 1; in_data = DW'(dval);
      end else begin
        coef_we = 0; in_valid = 0;
      end
      @(negedge clk);
      cnt++;
    end
    coef_we = 0; in_valid = 0;
    chk("R6 latency", cnt, TAPS + 2);
    chk(req, out_data, exp);
    @(negedge clk);
    chk("R6 single pulse", out_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint held;
    for (int i = 0; i < TAPS; i++) begin cm[i] = 0; hm[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 data after reset", out_data, 0);
    run(1000, 0, 0, "R1 zero coefficients");

    wcoef(0, 30000);  wcoef(1, -20000); wcoef(2, 65536);  wcoef(3, 100);
    wcoef(4, -131072); wcoef(5, 131071); wcoef(6, 5);     wcoef(7, -7);
    run(4000, 0, 0, "R2 written coefficients");

    for (int v = 0; v < NV; v++) run(STIM[v], 0, 0, SREQ[v]);

    run(-3000, 1, 99999, "R3 write while busy");
    run(2500, 0, 0, "R3 coefficient unchanged");
    run(1234, 2, 50000, "R4 offer while busy");
    run(-700, 0, 0, "R4 offered sample absent");

    held = out_data;
    repeat (6) @(negedge clk);
    chk("R9 hold", out_data, held);

    for (int i = 0; i < TAPS; i++) wcoef(i, 131071);
    for (int i = 0; i < TAPS; i++) run(131071, 0, 0, "R8 positive clamp");
    for (int i = 0; i < TAPS; i++) run(-131072, 0, 0, "R8 negative clamp");

    wcoef(0, 1);
    for (int i = 1; i < TAPS; i++) wcoef(i, 0);
    run(-1, 0, 0, "R8 floor negative");
    run(3, 0, 0, "R8 floor positive");
    run(-131072, 0, 0, "R8 unit scale");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule